// File: doc/BRIEF.md
# Pipeline Hazard Detection and Forwarding Unit

This block is the hazard-control logic for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory and writeback. Registers are read in decode and written only in writeback. Because of this, read-after-write is the only data hazard the unit has to resolve. Write-after-read and write-after-write ordering problems cannot arise. The unit compares the source fields of the instruction now in decode with the destination fields held in the execute and memory pipeline registers. From that comparison it produces every control signal the datapath needs to keep dependent instructions correct.

The ALU operand selects are worked out one cycle early, while the consumer is still in decode. They are loaded into registers as the consumer enters execute, so they reach the execute multiplexers straight from flops. The unit also handles four other cases:
- A load followed at once by a user of its result holds the front of the pipe for one cycle and puts a no-op into execute.
- A load followed at once by a store of that value does not stall. The store data is taken from the writeback register later, when the store is in the memory stage.
- Branches are resolved in decode. The unit holds a branch whose operands are still being produced, and bypasses a finished ALU result into the decode comparator.
- Under predict-not-taken, a taken branch squashes the instruction fetched after it, so a taken branch costs one cycle.

Top module: `hzd_ctrl`

## Requirements
- R1: While `rst` is high, at every clock edge `alu_sel_a`, `alu_sel_b` and `st_data_byp` are loaded with 0.
- R2: A used source in decode that equals a non-zero `ex_dst` with `ex_wr`=1 and `ex_load`=0 makes the matching ALU select 2'b10 (take the execute/memory result) after the next edge. If `ex_wr`=0, no match is made.
- R3: A used source that equals a non-zero `mem_dst` with `mem_wr`=1, and does not match execute, makes the matching select 2'b01 (take the writeback value) after the next edge. With no match the select is 2'b00 (take the register file value).
- R4: When a source matches both `ex_dst` and `mem_dst`, the younger result wins and the select is 2'b10.
- R5: Register number 0 is never a forwarding source and never causes a stall. A destination of 0 is ignored even when its write enable is set, including for loads.
- R6: A used source in decode that equals the destination of a load in execute (`ex_load`=1) raises `hold_front` and `bubble_ex` in the same cycle, and both selects become 2'b00 after the edge. A load already in the memory stage causes no stall and is forwarded with 2'b01.
- R7: When the decode instruction is a store (`id_store`=1) and only its data source (`id_src_b`) matches a load in execute, there is no stall. `st_data_byp` goes to 1 two edges later, when the store sits in the memory stage. A store whose address source matches the load stalls as in R6, and then no `st_data_byp` follows.
- R8: A branch in decode (`id_branch`=1) raises `hold_front` if any used source matches a writing instruction in execute (ALU or load), or matches a load in the memory stage.
- R9: A branch whose source matches a non-load result in the memory stage does not stall. It raises `cmp_byp_a` or `cmp_byp_b` for that operand, so the decode comparator takes the execute/memory result.
- R10: `squash_if` is 1 exactly when `id_branch`=1, `id_cond_true`=1 and there is no hold. `id_cond_true` has no effect when `id_branch`=0.
- R11: A source whose use flag (`id_use_a`/`id_use_b`) is 0 never forwards and never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src_a | input | REG_W | First source register of the decode instruction |
| id_src_b | input | REG_W | Second source register of the decode instruction (store data for stores) |
| id_use_a | input | 1 | First source is read |
| id_use_b | input | 1 | Second source is read |
| id_store | input | 1 | Decode instruction is a store |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_cond_true | input | 1 | Decode comparator says the branch is taken |
| ex_dst | input | REG_W | Destination held in the decode/execute register |
| ex_wr | input | 1 | That instruction writes a register |
| ex_load | input | 1 | That instruction is a load |
| mem_dst | input | REG_W | Destination held in the execute/memory register |
| mem_wr | input | 1 | That instruction writes a register |
| mem_load | input | 1 | That instruction is a load |
| hold_front | output | 1 | Hold the PC and the fetch/decode register |
| bubble_ex | output | 1 | Load a no-op into the decode/execute register |
| squash_if | output | 1 | Turn the fetched instruction into a no-op (taken branch) |
| cmp_byp_a | output | 1 | Decode comparator operand A from the execute/memory result |
| cmp_byp_b | output | 1 | Decode comparator operand B from the execute/memory result |
| alu_sel_a | output | 2 | Registered ALU operand A select: 00 register, 01 writeback, 10 execute/memory |
| alu_sel_b | output | 2 | Registered ALU operand B select, same encoding |
| st_data_byp | output | 1 | Registered: store data in the memory stage comes from the writeback value |

## Verification
The assertions assume that the stage-register inputs follow a real pipeline. In particular, in the cycle after `hold_front` the execute fields describe a no-op, and a load in execute moves to the memory stage on the next edge. Each table vector sets up one complete pipeline snapshot and checks the combinational outputs before the edge and the registered selects after it. The directed sequences that track a store across two edges drive the execute and memory fields as a pipeline would advance them. Between tests, idle cycles with every field at 0 return the registered state to no-forward.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_EXM = 2'b10
  } opsel_e;
endpackage

// File: rtl/hzd_src_cmp.sv
`timescale 1ns/1ps
module hzd_src_cmp #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             use_src,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  output logic             hit_ex,
  output logic             hit_mem
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic live;
  assign live    = use_src && (src != ZERO_REG);
  assign hit_ex  = live && ex_wr  && (ex_dst  == src);
  assign hit_mem = live && mem_wr && (mem_dst == src);
endmodule

// File: rtl/hzd_ctrl.sv
`timescale 1ns/1ps
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_use_a,
  input  logic             id_use_b,
  input  logic             id_store,
  input  logic             id_branch,
  input  logic             id_cond_true,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  output logic             hold_front,
  output logic             bubble_ex,
  output logic             squash_if,
  output logic             cmp_byp_a,
  output logic             cmp_byp_b,
  output logic [1:0]       alu_sel_a,
  output logic [1:0]       alu_sel_b,
  output logic             st_data_byp
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] src  [NSRC];
  logic [NSRC-1:0]  used;
  logic [NSRC-1:0]  hit_ex;
  logic [NSRC-1:0]  hit_mem;
  opsel_e           nsel [NSRC];

  assign src[0]  = id_src_a;
  assign src[1]  = id_src_b;
  assign used[0] = id_use_a;
  assign used[1] = id_use_b;

  // One comparator pair per source operand
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hzd_src_cmp #(.REG_W(REG_W)) u_cmp (
      .src     (src[i]),
      .use_src (used[i]),
      .ex_dst  (ex_dst),
      .ex_wr   (ex_wr),
      .mem_dst (mem_dst),
      .mem_wr  (mem_wr),
      .hit_ex  (hit_ex[i]),
      .hit_mem (hit_mem[i])
    );
  end

  // Load in execute feeding the next instruction; store data is exempt
  logic load_use;
  logic store_late;
  logic br_wait;
  logic stall;

  assign store_late = id_store && hit_ex[1] && ex_load;
  assign load_use   = ex_load && (hit_ex[0] || (hit_ex[1] && !id_store));
  assign br_wait    = id_branch &&
                      ((|hit_ex) || (mem_load && (|hit_mem)));
  assign stall      = load_use || br_wait;

  assign hold_front = stall;
  assign bubble_ex  = stall;
  assign squash_if  = id_branch && id_cond_true && !stall;
  assign cmp_byp_a  = id_branch && hit_mem[0] && !mem_load;
  assign cmp_byp_b  = id_branch && hit_mem[1] && !mem_load;

  // Select the consumer will need once it sits in execute
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      if (stall)
        nsel[i] = SEL_RF;
      else if (hit_ex[i])
        nsel[i] = ex_load ? SEL_RF : SEL_EXM;
      else if (hit_mem[i])
        nsel[i] = SEL_WB;
      else
        nsel[i] = SEL_RF;
    end
  end

  logic st_late_ex;

  always_ff @(posedge clk) begin
    if (rst) begin
      alu_sel_a   <= 2'b00;
      alu_sel_b   <= 2'b00;
      st_late_ex  <= 1'b0;
      st_data_byp <= 1'b0;
    end else begin
      alu_sel_a   <= nsel[0];
      alu_sel_b   <= nsel[1];
      st_late_ex  <= store_late && !stall;
      st_data_byp <= st_late_ex;
    end
  end
endmodule

// File: rtl/hzd_ctrl_chk.sv
`timescale 1ns/1ps
module hzd_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic             id_use_a,
  input logic             id_use_b,
  input logic             id_store,
  input logic             id_branch,
  input logic             ex_load,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_wr,
  input logic             hold_front,
  input logic             bubble_ex,
  input logic             squash_if,
  input logic [1:0]       alu_sel_a,
  input logic [1:0]       alu_sel_b,
  input logic             st_data_byp
);
  // R10
  no_squash_when_held_chk: assert property (@(posedge clk) disable iff (rst)
    squash_if |-> !hold_front);

  // R6
  held_then_plain_sel_chk: assert property (@(posedge clk) disable iff (rst)
    hold_front |=> (alu_sel_a == 2'b00) && (alu_sel_b == 2'b00));

  // R6
  bubble_matches_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bubble_ex == hold_front);

  // R8
  hold_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    hold_front |-> (ex_load || id_branch));

  // R5
  zero_src_a_chk: assert property (@(posedge clk) disable iff (rst)
    (id_src_a == '0) |=> (alu_sel_a == 2'b00));

  // R5
  zero_src_b_chk: assert property (@(posedge clk) disable iff (rst)
    (id_src_b == '0) |=> (alu_sel_b == 2'b00));

  // R11
  unused_a_chk: assert property (@(posedge clk) disable iff (rst)
    !id_use_a |=> (alu_sel_a == 2'b00));

  // R4
  sel_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_sel_a != 2'b11) && (alu_sel_b != 2'b11));

  // R2
  younger_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_front && id_use_b && (id_src_b != '0) && ex_wr && !ex_load &&
     (ex_dst == id_src_b)) |=> (alu_sel_b == 2'b10));

  // R7
  store_byp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    st_data_byp |-> ($past(id_store, 2) && $past(ex_load, 2)));
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_hzd_ctrl.sv
`timescale 1ns/1ps
module tb_hzd_ctrl;
  localparam int REG_W  = 5;
  localparam int NVEC   = 17;
  localparam int WDOG_T = 200000;

  typedef struct packed {
    logic [7:0]       req;
    logic [REG_W-1:0] s1, s2;
    logic             u1, u2, st, br, tk;
    logic [REG_W-1:0] exd;
    logic             exw, exl;
    logic [REG_W-1:0] md;
    logic             mw, ml;
    logic             xs, xf, xca, xcb;
    logic [1:0]       xa, xb;
  } vec_t;

  function automatic vec_t mk(int req, int s1, int s2, int u1, int u2, int st,
                              int br, int tk, int exd, int exw, int exl,
                              int md, int mw, int ml, int xs, int xf,
                              int xca, int xcb, int xa, int xb);
    vec_t v;
    v.req = 8'(req);  v.s1 = REG_W'(s1); v.s2 = REG_W'(s2);
    v.u1 = 1'(u1); v.u2 = 1'(u2); v.st = 1'(st); v.br = 1'(br); v.tk = 1'(tk);
    v.exd = REG_W'(exd); v.exw = 1'(exw); v.exl = 1'(exl);
    v.md = REG_W'(md); v.mw = 1'(mw); v.ml = 1'(ml);
    v.xs = 1'(xs); v.xf = 1'(xf); v.xca = 1'(xca); v.xcb = 1'(xcb);
    v.xa = 2'(xa); v.xb = 2'(xb);
    return v;
  endfunction

  // req, s1,s2,u1,u2,st,br,tk, exd,exw,exl, md,mw,ml, stall,squash,ca,cb, sela,selb
  localparam vec_t TBL [NVEC] = '{
    mk(2,  3, 4,1,1,0,0,0,  3,1,0,  0,0,0, 0,0,0,0, 2,0), // R2 execute result
    mk(3,  5, 6,1,1,0,0,0,  0,0,0,  6,1,0, 0,0,0,0, 0,1), // R3 writeback value
    mk(4,  7, 7,1,1,0,0,0,  7,1,0,  7,1,0, 0,0,0,0, 2,2), // R4 younger first
    mk(5,  0, 0,1,1,0,0,0,  0,1,0,  0,1,0, 0,0,0,0, 0,0), // R5 reg 0 writes
    mk(5,  0, 9,1,1,0,0,0,  0,1,1,  0,0,0, 0,0,0,0, 0,0), // R5 load to reg 0
    mk(11, 8, 9,0,0,0,0,0,  8,1,0,  9,1,0, 0,0,0,0, 0,0), // R11 unused fields
    mk(6, 10, 1,1,0,0,0,0, 10,1,1,  0,0,0, 1,0,0,0, 0,0), // R6 load-use
    mk(7,  2,11,1,1,1,0,0, 11,1,1,  0,0,0, 0,0,0,0, 0,0), // R7 store data only
    mk(6, 11,11,1,1,1,0,0, 11,1,1,  0,0,0, 1,0,0,0, 0,0), // R6 store address
    mk(8, 12, 0,1,0,0,1,1, 12,1,0,  0,0,0, 1,0,0,0, 0,0), // R8 ALU in execute
    mk(8, 13, 0,1,0,0,1,0,  0,0,0, 13,1,1, 1,0,0,0, 0,0), // R8 load in memory
    mk(9, 14,15,1,1,0,1,0,  0,0,0, 15,1,0, 0,0,0,1, 0,1), // R9 comparator bypass
    mk(10, 1, 2,1,1,0,1,1,  0,0,0,  0,0,0, 0,1,0,0, 0,0), // R10 taken squash
    mk(10, 1, 2,1,1,0,0,1,  0,0,0,  0,0,0, 0,0,0,0, 0,0), // R10 not a branch
    mk(2,  3, 0,1,0,0,0,0,  3,0,0,  0,0,0, 0,0,0,0, 0,0), // R2 no write enable
    mk(6, 10, 0,1,0,0,0,0,  0,0,0, 10,1,1, 0,0,0,0, 1,0), // R6 load one further
    mk(8, 16,17,1,1,0,1,1,  0,0,0, 17,1,0, 0,1,0,1, 0,1)  // R8 no stall, R9 bypass
  };

  logic             clk = 1'b0;
  logic             rst;
  logic [REG_W-1:0] id_src_a, id_src_b, ex_dst, mem_dst;
  logic             id_use_a, id_use_b, id_store, id_branch, id_cond_true;
  logic             ex_wr, ex_load, mem_wr, mem_load;
  logic             hold_front, bubble_ex, squash_if, cmp_byp_a, cmp_byp_b;
  logic [1:0]       alu_sel_a, alu_sel_b;
  logic             st_data_byp;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hzd_ctrl #(.REG_W(REG_W)) dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    id_src_a = v.s1; id_src_b = v.s2; id_use_a = v.u1; id_use_b = v.u2;
    id_store = v.st; id_branch = v.br; id_cond_true = v.tk;
    ex_dst = v.exd; ex_wr = v.exw; ex_load = v.exl;
    mem_dst = v.md; mem_wr = v.mw; mem_load = v.ml;
  endtask

  task automatic idle();
    drive(mk(0, 0,0,0,0,0,0,0, 0,0,0, 0,0,0, 0,0,0,0, 0,0));
  endtask

  initial begin
    #(WDOG_T * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    string tag;
    rst = 1'b1;
    drive(TBL[2]);
    repeat (3) @(posedge clk);
    #1;
    // R1: selects stay zero under reset despite matching inputs
    chk("R1", "alu_sel_a", alu_sel_a, 0);
    chk("R1", "alu_sel_b", alu_sel_b, 0);
    chk("R1", "st_data_byp", st_data_byp, 0);
    @(negedge clk);
    rst = 1'b0;
    idle();
    @(posedge clk);

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      drive(TBL[k]);
      tag = $sformatf("R%0d", TBL[k].req);
      #1;
      chk(tag, $sformatf("v%0d hold_front", k), hold_front, TBL[k].xs);
      chk(tag, $sformatf("v%0d bubble_ex", k), bubble_ex, TBL[k].xs);
      chk(tag, $sformatf("v%0d squash_if", k), squash_if, TBL[k].xf);
      chk(tag, $sformatf("v%0d cmp_byp_a", k), cmp_byp_a, TBL[k].xca);
      chk(tag, $sformatf("v%0d cmp_byp_b", k), cmp_byp_b, TBL[k].xcb);
      @(posedge clk);
      #1;
      chk(tag, $sformatf("v%0d alu_sel_a", k), alu_sel_a, TBL[k].xa);
      chk(tag, $sformatf("v%0d alu_sel_b", k), alu_sel_b, TBL[k].xb);
    end

    // R7: load then store of its value, store reaches memory two edges later
    @(negedge clk); idle();
    @(negedge clk);
    drive(TBL[7]);
    @(negedge clk);
    idle(); mem_dst = 5'd11; mem_wr = 1'b1; mem_load = 1'b1;
    #1;
    chk("R7", "st_data_byp one edge on", st_data_byp, 0);
    @(negedge clk);
    idle();
    #1;
    chk("R7", "st_data_byp store in memory", st_data_byp, 1);
    @(posedge clk); #1;
    chk("R7", "st_data_byp after store leaves", st_data_byp, 0);

    // R7: address dependence stalls, so no later store-data bypass
    @(negedge clk);
    drive(TBL[8]);
    @(negedge clk);
    idle();
    @(posedge clk); #1;
    chk("R7", "st_data_byp after held store", st_data_byp, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule